// File: doc/BRIEF.md
# Exception and Interrupt Acceptance Unit

This block decides, at each instruction boundary of a small RISC core, whether the core leaves its current flow for a handler. It watches four kinds of source. The first is a misaligned DMA data access. The second is the rising edge of the non-maskable interrupt pin. The third is a 4-bit encoded interrupt level. The fourth is a set of IRQ request lines, each with a programmable 4-bit priority. The block compares these sources with the current status register and picks at most one event.

When it takes an event, it raises a one-cycle `take` strobe. With the strobe it presents the return PC and the old SR to save, the event code and which event code register to write, the updated SR and the branch target. The branch target is formed from the vector base. The pipeline, the bank switching and the handler code use these values. They are outside this block.

Top module: `exc_accept`

## Requirements
- R1: A DMA access marks a pending address error when `dma_valid` is 1 and the access is misaligned. A word access (`dma_long`=0) is misaligned when `dma_addr_lo[0]` is 1. A longword access (`dma_long`=1) is misaligned when `dma_addr_lo` is not 0. Taking the error pulses `expevt_we` with code 0x5C0 and branches to `vbr`+0x100. The address error is not blocked by BL or IMASK.
- R2: A rising edge on `nmi_pin` marks a pending NMI. Taking it pulses `intevt_we` with code 0x1C0 and branches to `vbr`+0x600, whatever the IMASK value.
- R3: While SR.BL (`sr_in[6]`) is 1, no NMI, level or IRQ interrupt is taken. A pending NMI is held until it is taken and is then cleared, so one edge yields exactly one take.
- R4: The encoded level is taken only when it is nonzero and strictly greater than IMASK (`sr_in[3:0]`). It writes code 0x200 + level×0x20 with `intevt_we` and branches to `vbr`+0x600.
- R5: IRQ line i is eligible when `irq_req[i]` is 1 and its priority `irq_prio[4i+3:4i]` is strictly greater than IMASK. Taking it writes code 0x600 + i×0x20 with `intevt_we` and branches to `vbr`+0x600.
- R6: When several sources are ready at one boundary, the order is: address error, then NMI, then the encoded level, then the IRQs.
- R7: Among eligible IRQs the highest priority wins. On equal priority the lowest index wins.
- R8: On a take, `save_pc` equals `next_pc` and `save_sr` equals `sr_in` at the boundary. `new_sr` has BL, MD and RB (bits 6,5,4) set to 1 and IMASK unchanged.
- R9: An event is taken only in a cycle with `boundary`=1. Outputs are valid for the single cycle after that edge, together with `take`. No event is taken in the cycle right after a take.
- R10: After reset `take` is 0 and no address error or NMI is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Current cycle is an instruction boundary |
| nmi_pin | input | 1 | Non-maskable interrupt pin, rising-edge sensitive |
| irl_lvl | input | 4 | Encoded interrupt level, 0 = none |
| irq_req | input | NIRQ | IRQ request lines |
| irq_prio | input | 4*NIRQ | Priority per IRQ line, 4 bits each |
| dma_valid | input | 1 | DMA data access present this cycle |
| dma_long | input | 1 | 1 = longword access, 0 = word access |
| dma_addr_lo | input | 2 | Two low bits of the DMA address |
| sr_in | input | 7 | Current SR: [6] BL, [5] MD, [4] RB, [3:0] IMASK |
| vbr | input | 32 | Vector base |
| next_pc | input | 32 | PC of the next instruction |
| take | output | 1 | Event taken; other outputs valid |
| save_pc | output | 32 | PC value to save |
| save_sr | output | 7 | SR value to save |
| new_sr | output | 7 | SR value after acceptance |
| expevt_we | output | 1 | Write the exception event code register |
| intevt_we | output | 1 | Write both interrupt event code registers |
| evt_code | output | 12 | Event code to write |
| branch_pc | output | 32 | Handler address |

## Verification
A vector table drives each source alone at its limits. These include word and longword accesses at every low address value, levels equal to, just above and far above IMASK, level 0, and IRQ priorities just at and just over IMASK. The same table then drives mixed patterns in which two or more sources are ready together. The single-source patterns show whether each acceptance rule and code formula is right. The mixed patterns show whether the priority order and the IRQ tie rule are right. Directed sequences cover an NMI edge arriving under BL, a request held across many boundaries (to expose the rule that bars a take in the cycle after a take), and SR with MD and RB set differently from BL, so that the saved and updated SR fields can be told apart.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    EV_NONE = 3'd0,
    EV_AERR = 3'd1,
    EV_NMI  = 3'd2,
    EV_IRL  = 3'd3,
    EV_IRQ  = 3'd4
  } ev_kind_t;

  localparam int SR_W     = 7;
  localparam int SR_BL    = 6;
  localparam int LVL_W    = 4;
  localparam int CODE_W   = 12;

  // misalignment test on the two low address bits
  function automatic logic misaligned(input logic is_long, input logic [1:0] lo);
    return is_long ? (lo != 2'b00) : lo[0];
  endfunction

  // code for an encoded-level interrupt: 0x200 + level * 0x20
  function automatic logic [CODE_W-1:0] level_code(input logic [LVL_W-1:0] lvl);
    return 12'h200 + {3'b000, lvl, 5'b00000};
  endfunction

  // SR after acceptance: BL, MD, RB forced high, mask kept
  function automatic logic [SR_W-1:0] entry_sr(input logic [SR_W-1:0] sr);
    return {3'b111, sr[3:0]};
  endfunction

endpackage

// File: rtl/exc_aerr_latch.sv
module exc_aerr_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dma_valid,
  input  logic       dma_long,
  input  logic [1:0] dma_addr_lo,
  input  logic       clr,
  output logic       pend
);
  import exc_pkg::*;

  logic bad_access;
  assign bad_access = dma_valid && misaligned(dma_long, dma_addr_lo);

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend && !clr) || bad_access;
  end
endmodule

// File: rtl/exc_nmi_latch.sv
module exc_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic clr,
  output logic pend
);
  logic pin_q;
  logic rise;
  assign rise = pin && !pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      pin_q <= pin;
      pend  <= (pend && !clr) || rise;
    end
  end
endmodule

// File: rtl/exc_irq_arb.sv
module exc_irq_arb #(
  parameter int NIRQ = 4,
  parameter int PW   = 4,
  parameter int IW   = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic [NIRQ-1:0]    req,
  input  logic [NIRQ*PW-1:0] prio,
  input  logic [PW-1:0]      imask,
  output logic               hit,
  output logic [IW-1:0]      idx
);
  logic [PW-1:0] best;

  // scanned from the top index down; ">=" lets a lower index take a tie
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (req[i] && (prio[i*PW +: PW] > imask) &&
          (!hit || (prio[i*PW +: PW] >= best))) begin
        hit  = 1'b1;
        best = prio[i*PW +: PW];
        idx  = IW'(i);
      end
    end
  end
endmodule

// File: rtl/exc_accept.sv
module exc_accept #(
  parameter int           NIRQ          = 4,
  parameter logic [11:0]  AERR_CODE     = 12'h5C0,
  parameter logic [11:0]  NMI_CODE      = 12'h1C0,
  parameter logic [11:0]  IRQ_CODE_BASE = 12'h600,
  parameter logic [31:0]  EXC_OFFSET    = 32'h0000_0100,
  parameter logic [31:0]  INT_OFFSET    = 32'h0000_0600
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 boundary,
  input  logic                 nmi_pin,
  input  logic [3:0]           irl_lvl,
  input  logic [NIRQ-1:0]      irq_req,
  input  logic [NIRQ*4-1:0]    irq_prio,
  input  logic                 dma_valid,
  input  logic                 dma_long,
  input  logic [1:0]           dma_addr_lo,
  input  logic [6:0]           sr_in,
  input  logic [31:0]          vbr,
  input  logic [31:0]          next_pc,
  output logic                 take,
  output logic [31:0]          save_pc,
  output logic [6:0]           save_sr,
  output logic [6:0]           new_sr,
  output logic                 expevt_we,
  output logic                 intevt_we,
  output logic [11:0]          evt_code,
  output logic [31:0]          branch_pc
);
  import exc_pkg::*;

  localparam int PW = LVL_W;
  localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  // named internal events
  logic          aerr_pend, nmi_pend;
  logic          aerr_clr,  nmi_clr;
  logic          irq_hit;
  logic [IW-1:0] irq_idx;
  logic          int_open;
  logic          nmi_ok, irl_ok, irq_ok;
  logic          gate, accept;
  ev_kind_t      kind;
  logic [11:0]   code_d;
  logic [31:0]   target_d;

  exc_aerr_latch u_aerr (
    .clk(clk), .rst_n(rst_n), .dma_valid(dma_valid), .dma_long(dma_long),
    .dma_addr_lo(dma_addr_lo), .clr(aerr_clr), .pend(aerr_pend)
  );

  exc_nmi_latch u_nmi (
    .clk(clk), .rst_n(rst_n), .pin(nmi_pin), .clr(nmi_clr), .pend(nmi_pend)
  );

  exc_irq_arb #(.NIRQ(NIRQ), .PW(PW), .IW(IW)) u_arb (
    .req(irq_req), .prio(irq_prio), .imask(sr_in[3:0]),
    .hit(irq_hit), .idx(irq_idx)
  );

  function automatic logic [11:0] irq_code(input logic [IW-1:0] i);
    return IRQ_CODE_BASE + 12'({i, 5'b00000});
  endfunction

  assign int_open = !sr_in[SR_BL];
  assign nmi_ok   = nmi_pend && int_open;
  assign irl_ok   = int_open && (irl_lvl != 4'd0) && (irl_lvl > sr_in[3:0]);
  assign irq_ok   = int_open && irq_hit;
  assign gate     = boundary && !take;

  always_comb begin
    kind     = EV_NONE;
    code_d   = '0;
    target_d = vbr + INT_OFFSET;
    if (aerr_pend) begin
      kind     = EV_AERR;
      code_d   = AERR_CODE;
      target_d = vbr + EXC_OFFSET;
    end else if (nmi_ok) begin
      kind   = EV_NMI;
      code_d = NMI_CODE;
    end else if (irl_ok) begin
      kind   = EV_IRL;
      code_d = level_code(irl_lvl);
    end else if (irq_ok) begin
      kind   = EV_IRQ;
      code_d = irq_code(irq_idx);
    end
  end

  assign accept   = gate && (kind != EV_NONE);
  assign aerr_clr = accept && (kind == EV_AERR);
  assign nmi_clr  = accept && (kind == EV_NMI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take      <= 1'b0;
      save_pc   <= '0;
      save_sr   <= '0;
      new_sr    <= '0;
      expevt_we <= 1'b0;
      intevt_we <= 1'b0;
      evt_code  <= '0;
      branch_pc <= '0;
    end else begin
      take      <= accept;
      expevt_we <= accept && (kind == EV_AERR);
      intevt_we <= accept && (kind != EV_AERR);
      if (accept) begin
        save_pc   <= next_pc;
        save_sr   <= sr_in;
        new_sr    <= entry_sr(sr_in);
        evt_code  <= code_d;
        branch_pc <= target_d;
      end
    end
  end
endmodule

// File: rtl/exc_accept_chk.sv
module exc_accept_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary,
  input logic [6:0]  sr_in,
  input logic [31:0] vbr,
  input logic        take,
  input logic        expevt_we,
  input logic        intevt_we,
  input logic [11:0] evt_code,
  input logic [31:0] branch_pc,
  input logic [6:0]  new_sr,
  input logic        nmi_pend,
  input logic        nmi_clr
);
  // R9
  take_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

  // R9
  take_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(boundary));

  // R3
  bl_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && intevt_we) |-> !$past(sr_in[6]));

  // R8
  sr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (new_sr[6:4] == 3'b111) && (new_sr[3:0] == $past(sr_in[3:0])));

  // R1
  aerr_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && expevt_we) |-> (evt_code == 12'h5C0) && (branch_pc == $past(vbr) + 32'h100));

  // R6
  one_code_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $onehot({expevt_we, intevt_we}));

  // R3
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !nmi_clr) |=> nmi_pend);

  // R10
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> !expevt_we && !intevt_we);
endmodule

bind exc_accept exc_accept_chk u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .sr_in(sr_in), .vbr(vbr),
  .take(take), .expevt_we(expevt_we), .intevt_we(intevt_we),
  .evt_code(evt_code), .branch_pc(branch_pc), .new_sr(new_sr),
  .nmi_pend(nmi_pend), .nmi_clr(nmi_clr)
);

// File: tb/sim_exc_accept.sv
module sim_exc_accept;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 4;
  // priorities: irq3=9, irq2=5, irq1=9, irq0=3
  localparam logic [15:0] PRIO = 16'h9593;
  localparam logic [31:0] VBR  = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary = 1'b0, nmi_pin = 1'b0, dma_valid = 1'b0, dma_long = 1'b0;
  logic [1:0] dma_addr_lo = '0;
  logic [3:0] irl_lvl = '0;
  logic [NIRQ-1:0] irq_req = '0;
  logic [6:0] sr_in = 7'h0F;
  logic [31:0] next_pc = 32'h0000_1234;
  logic take, expevt_we, intevt_we;
  logic [31:0] save_pc, branch_pc;
  logic [6:0] save_sr, new_sr;
  logic [11:0] evt_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_accept #(.NIRQ(NIRQ)) u0 (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .nmi_pin(nmi_pin),
    .irl_lvl(irl_lvl), .irq_req(irq_req), .irq_prio(PRIO),
    .dma_valid(dma_valid), .dma_long(dma_long), .dma_addr_lo(dma_addr_lo),
    .sr_in(sr_in), .vbr(VBR), .next_pc(next_pc), .take(take),
    .save_pc(save_pc), .save_sr(save_sr), .new_sr(new_sr),
    .expevt_we(expevt_we), .intevt_we(intevt_we), .evt_code(evt_code),
    .branch_pc(branch_pc)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // fields: nmi aerr long addr[1:0] bl imask irl irq | take exc code offset
  localparam int NV = 19;
  localparam logic [43:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,2'd1,1'b0,4'd15,4'd0, 4'b0000, 1'b1,1'b1,12'h5C0,12'h100}, // R1 word @1
    {1'b0,1'b1,1'b0,2'd2,1'b0,4'd15,4'd0, 4'b0000, 1'b0,1'b0,12'h000,12'h000}, // R1 word @2 ok
    {1'b0,1'b1,1'b1,2'd2,1'b0,4'd15,4'd0, 4'b0000, 1'b1,1'b1,12'h5C0,12'h100}, // R1 long @2
    {1'b0,1'b1,1'b1,2'd0,1'b0,4'd15,4'd0, 4'b0000, 1'b0,1'b0,12'h000,12'h000}, // R1 long @0 ok
    {1'b1,1'b0,1'b0,2'd0,1'b0,4'd15,4'd0, 4'b0000, 1'b1,1'b0,12'h1C0,12'h600}, // R2 nmi mask 15
    {1'b1,1'b0,1'b0,2'd0,1'b1,4'd0, 4'd0, 4'b0000, 1'b0,1'b0,12'h000,12'h000}, // R3 nmi under BL
    {1'b0,1'b0,1'b0,2'd0,1'b0,4'd4, 4'd5, 4'b0000, 1'b1,1'b0,12'h2A0,12'h600}, // R4 5 > 4
    {1'b0,1'b0,1'b0,2'd0,1'b0,4'd5, 4'd5, 4'b0000, 1'b0,1'b0,12'h000,12'h000}, // R4 5 = 5
    {1'b0,1'b0,1'b0,2'd0,1'b0,4'd0, 4'd0, 4'b0000, 1'b0,1'b0,12'h000,12'h000}, // R4 level 0
    {1'b0,1'b0,1'b0,2'd0,1'b0,4'd14,4'd15,4'b0000, 1'b1,1'b0,12'h3E0,12'h600}, // R4 15 > 14
    {1'b0,1'b0,1'b0,2'd0,1'b0,4'd2, 4'd0, 4'b0001, 1'b1,1'b0,12'h600,12'h600}, // R5 prio 3 > 2
    {1'b0,1'b0,1'b0,2'd0,1'b0,4'd3, 4'd0, 4'b0001, 1'b0,1'b0,12'h000,12'h000}, // R5 prio 3 = 3
    {1'b0,1'b0,1'b0,2'd0,1'b0,4'd4, 4'd0, 4'b1111, 1'b1,1'b0,12'h620,12'h600}, // R7 tie -> 1
    {1'b0,1'b0,1'b0,2'd0,1'b0,4'd0, 4'd0, 4'b1101, 1'b1,1'b0,12'h660,12'h600}, // R7 high -> 3
    {1'b0,1'b0,1'b0,2'd0,1'b0,4'd0, 4'd3, 4'b0010, 1'b1,1'b0,12'h260,12'h600}, // R6 irl > irq
    {1'b1,1'b0,1'b0,2'd0,1'b0,4'd0, 4'd15,4'b0000, 1'b1,1'b0,12'h1C0,12'h600}, // R6 nmi > irl
    {1'b1,1'b1,1'b0,2'd3,1'b0,4'd0, 4'd0, 4'b0000, 1'b1,1'b1,12'h5C0,12'h100}, // R6 aerr > nmi
    {1'b0,1'b0,1'b0,2'd0,1'b1,4'd0, 4'd0, 4'b1111, 1'b0,1'b0,12'h000,12'h000}, // R3 irq under BL
    {1'b0,1'b0,1'b0,2'd0,1'b1,4'd0, 4'd8, 4'b0000, 1'b0,1'b0,12'h000,12'h000}  // R3 irl under BL
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1, 2, 3:          return "R1";
      4:                   return "R2";
      5, 17, 18:           return "R3";
      6, 7, 8, 9:          return "R4";
      10, 11:              return "R5";
      12, 13:              return "R7";
      default:             return "R6";
    endcase
  endfunction

  task automatic quiet();
    boundary = 1'b0; nmi_pin = 1'b0; dma_valid = 1'b0; irl_lvl = '0;
    irq_req = '0; sr_in = 7'h0F;
  endtask

  // take every pending event left behind, then idle one cycle
  task automatic drain();
    quiet();
    boundary = 1'b1;
    repeat (4) @(negedge clk);
    boundary = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    quiet();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(take === 1'b0, "R10", "take in reset", 32'(take), 0);
    rst_n = 1'b1;
    boundary = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(take === 1'b0, "R10", "nothing pending after reset", 32'(take), 0);
    boundary = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [43:0] e;
      e = VEC[v];
      quiet();
      nmi_pin = e[43]; dma_valid = e[42]; dma_long = e[41]; dma_addr_lo = e[40:39];
      @(negedge clk);
      nmi_pin = 1'b0; dma_valid = 1'b0;
      sr_in = {e[38], 2'b00, e[37:34]};
      irl_lvl = e[33:30]; irq_req = e[29:26];
      next_pc = 32'h0000_1000 + 32'(v * 4);
      boundary = 1'b1;
      @(negedge clk);
      chk(take === e[25], tag_of(v), $sformatf("vec %0d take", v), 32'(take), 32'(e[25]));
      if (e[25]) begin
        chk(evt_code === e[23:12], tag_of(v), $sformatf("vec %0d code", v),
            32'(evt_code), 32'(e[23:12]));
        chk(expevt_we === e[24] && intevt_we === !e[24], tag_of(v),
            $sformatf("vec %0d code register", v), {30'b0, expevt_we, intevt_we},
            {30'b0, e[24], !e[24]});
        chk(branch_pc === VBR + 32'(e[11:0]), tag_of(v), $sformatf("vec %0d branch", v),
            branch_pc, VBR + 32'(e[11:0]));
        chk(save_pc === 32'h0000_1000 + 32'(v * 4), "R8", $sformatf("vec %0d save_pc", v),
            save_pc, 32'h0000_1000 + 32'(v * 4));
        chk(new_sr === {3'b111, e[37:34]}, "R8", $sformatf("vec %0d new_sr", v),
            32'(new_sr), 32'({3'b111, e[37:34]}));
      end
      drain();
    end

    // R3: NMI edge under BL is held, then taken once when BL clears
    quiet();
    sr_in = 7'h40;
    nmi_pin = 1'b1;
    @(negedge clk);
    nmi_pin = 1'b0;
    boundary = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(take === 1'b0, "R3", "nmi held while BL", 32'(take), 0);
    end
    sr_in = 7'h0F;
    @(negedge clk);
    chk(take === 1'b1 && evt_code === 12'h1C0, "R3", "held nmi taken",
        32'(evt_code), 32'h1C0);
    repeat (3) begin
      @(negedge clk);
      chk(take === 1'b0, "R3", "nmi latch cleared", 32'(take), 0);
    end
    drain();

    // R9: no take without boundary; held request takes every other cycle
    quiet();
    sr_in = 7'h00; irl_lvl = 4'd7;
    repeat (2) begin
      @(negedge clk);
      chk(take === 1'b0, "R9", "no take off boundary", 32'(take), 0);
    end
    boundary = 1'b1;
    @(negedge clk);
    chk(take === 1'b1, "R9", "take on boundary", 32'(take), 1);
    @(negedge clk);
    chk(take === 1'b0, "R9", "gap after take", 32'(take), 0);
    @(negedge clk);
    chk(take === 1'b1, "R9", "take after gap", 32'(take), 1);
    drain();

    // R8: SR with MD set, RB clear, mask 3
    quiet();
    sr_in = 7'b0100011; irl_lvl = 4'd9; next_pc = 32'hCAFE_0010;
    boundary = 1'b1;
    @(negedge clk);
    chk(save_sr === 7'b0100011, "R8", "save_sr", 32'(save_sr), 32'h23);
    chk(new_sr === 7'b1110011, "R8", "new_sr mask kept", 32'(new_sr), 32'h73);
    chk(save_pc === 32'hCAFE_0010, "R8", "save_pc", save_pc, 32'hCAFE_0010);
    chk(evt_code === 12'h320, "R4", "level 9 code", 32'(evt_code), 32'h320);
    drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule